// File: doc/BRIEF.md
# Worst-case-transition avoiding bus encoder

This block is the encode and decode pair for a narrow parallel link that leaves the chip. The link is split into lanes of three wires. Each lane carries two payload bits per symbol. The transmit side holds its codeword in a register and drives it onto the lane. Only four of the eight three-bit words are ever used, and neither 000 nor 111 is among them. So no lane can switch all three of its lines the same way on one edge, which is the worst case for ground bounce and supply droop. Giving up one wire of capacity per lane buys a higher safe toggle rate.

The receive side registers the incoming lane words and decodes them. It presents the payload with a valid flag, and it reports per lane any word that is not one of the four codewords. On idle cycles the transmitter holds its last word, so an idle link does not toggle. The decoder samples continuously, so during idle it keeps reporting the word that is being held on the lane.

Top module: `ssn_bus_link`

## Requirements
- R1: For lane k, payload bits [2k+1:2k] map to bus bits [3k+2:3k] as follows: 00 gives 001, 01 gives 010, 10 gives 100, and 11 gives 011.
- R2: While rst_ni is low, every lane of bus_o reads 001, rx_data_o reads 0, rx_valid_o reads 0 and rx_err_o reads 0.
- R3: When tx_valid_i is high at a rising clock edge, the codeword for tx_data_i appears on bus_o right after that edge.
- R4: When tx_valid_i is low at a rising clock edge, bus_o keeps its value, whatever tx_data_i holds.
- R5: No lane of bus_o ever shows 000 or 111. Therefore no lane ever steps directly from 000 to 111 or from 111 to 000.
- R6: At each rising edge the decoder samples bus_i. Right after that edge, rx_data_o carries the payload of the sampled word, with bits placed as in R1.
- R7: A lane word of 000, 101, 110 or 111 sets that lane's bit in rx_err_o one edge after it is sampled, and it forces rx_valid_o low for that cycle. rx_valid_o is high only when every lane holds a legal codeword.
- R8: When bus_o is looped back to bus_i, any sequence of accepted payloads comes out of rx_data_o unchanged, two edges after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 2*LANES | Payload to send |
| tx_valid_i | input | 1 | Payload strobe |
| bus_o | output | 3*LANES | Registered encoded bus |
| bus_i | input | 3*LANES | Encoded bus as received |
| rx_data_o | output | 2*LANES | Decoded payload |
| rx_valid_o | output | 1 | All lanes hold legal codewords |
| rx_err_o | output | LANES | Per-lane illegal word flag |

## Verification
Two functions can fall in the same cycle. One is the decoder reporting an illegal word on one lane. The other is a legal payload being decoded on the other lane, or new data being accepted on the transmit side. The bench provokes this by corrupting one lane of the looped-back bus while the other lane carries a normal codeword. It then checks that only the corrupted lane's error bit rises and that rx_valid_o drops. Once the corruption is removed, it checks that the round trip resumes with the word the transmitter has been holding.

// File: rtl/ssn_code_pkg.sv
package ssn_code_pkg;
  localparam int unsigned SYM_W = 3;
  localparam int unsigned PAY_W = 2;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [PAY_W-1:0] pay_t;

  localparam sym_t RESET_SYM = 3'b001;

  function automatic sym_t enc_sym(pay_t d);
    case (d)
      2'b00:   enc_sym = 3'b001;
      2'b01:   enc_sym = 3'b010;
      2'b10:   enc_sym = 3'b100;
      default: enc_sym = 3'b011;
    endcase
  endfunction

  function automatic logic sym_legal(sym_t s);
    sym_legal = (s == 3'b001) || (s == 3'b010) || (s == 3'b100) || (s == 3'b011);
  endfunction

  function automatic pay_t dec_sym(sym_t s);
    case (s)
      3'b010:  dec_sym = 2'b01;
      3'b100:  dec_sym = 2'b10;
      3'b011:  dec_sym = 2'b11;
      default: dec_sym = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/ssn_lane_enc.sv
module ssn_lane_enc
  import ssn_code_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  pay_t data_i,
  output sym_t sym_o
);
  sym_t sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sym_q <= RESET_SYM;
    else if (load_i) sym_q <= enc_sym(data_i);
  end

  assign sym_o = sym_q;

  a_r5_legal_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_q != 3'b000 && sym_q != 3'b111);
  a_r5_no_rise_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_q == 3'b000) |=> (sym_q != 3'b111));
  a_r5_no_fall_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_q == 3'b111) |=> (sym_q != 3'b000));
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sym_q));
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ($countones(sym_q) == 1 || sym_q == 3'b011));
endmodule

// File: rtl/ssn_lane_dec.sv
module ssn_lane_dec
  import ssn_code_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sym_t sym_i,
  output pay_t data_o,
  output logic ok_o,
  output logic err_o
);
  pay_t data_q;
  logic ok_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      data_q <= dec_sym(sym_i);
      ok_q   <= sym_legal(sym_i);
      err_q  <= !sym_legal(sym_i);
    end
  end

  assign data_o = data_q;
  assign ok_o   = ok_q;
  assign err_o  = err_q;

  a_r7_all_ones_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_i == 3'b111) |=> err_q);
  a_r7_all_zero_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_i == 3'b000) |=> err_q);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_q && err_q));
endmodule

// File: rtl/ssn_bus_link.sv
module ssn_bus_link
  import ssn_code_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned DW = PAY_W * LANES,
  localparam int unsigned BW = SYM_W * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic [BW-1:0] bus_o,
  input  logic [BW-1:0] bus_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic [LANES-1:0] rx_err_o
);
  logic [LANES-1:0] lane_ok;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ssn_lane_enc i_enc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tx_valid_i),
      .data_i (tx_data_i[PAY_W*k +: PAY_W]),
      .sym_o  (bus_o[SYM_W*k +: SYM_W])
    );
    ssn_lane_dec i_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sym_i  (bus_i[SYM_W*k +: SYM_W]),
      .data_o (rx_data_o[PAY_W*k +: PAY_W]),
      .ok_o   (lane_ok[k]),
      .err_o  (rx_err_o[k])
    );
  end

  assign rx_valid_o = &lane_ok;

  a_r7_err_blocks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_err_o) |-> !rx_valid_o);
  a_r6_valid_means_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_err_o == '0));
endmodule

// File: tb/test_ssn_bus_link.sv
module test_ssn_bus_link;
  localparam int LANES = 2;
  localparam int DW = 2 * LANES;
  localparam int BW = 3 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic [BW-1:0] bus_o, bus_in, inj_word;
  logic inj = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_valid;
  logic [LANES-1:0] rx_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign bus_in = inj ? inj_word : bus_o;

  ssn_bus_link #(.LANES(LANES)) i_ssn_bus_link (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .bus_o(bus_o), .bus_i(bus_in), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_err_o(rx_err)
  );

  // {payload, expected bus}, lane 1 in the upper bits
  localparam logic [9:0] VEC [8] = '{
    {4'b0000, 6'b001_001}, {4'b0001, 6'b001_010}, {4'b0010, 6'b001_100},
    {4'b0011, 6'b001_011}, {4'b0100, 6'b010_001}, {4'b1001, 6'b100_010},
    {4'b1110, 6'b011_100}, {4'b1111, 6'b011_011}
  };

  function automatic logic [2:0] model_enc(logic [1:0] d);
    case (d)
      2'b00: return 3'b001;
      2'b01: return 3'b010;
      2'b10: return 3'b100;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [BW-1:0] model_bus(logic [DW-1:0] d);
    return {model_enc(d[3:2]), model_enc(d[1:0])};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [BW-1:0] last_bus;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < LANES; k++) begin
        tests++;
        if ((last_bus[3*k +: 3] == 3'b000 && bus_o[3*k +: 3] == 3'b111) ||
            (last_bus[3*k +: 3] == 3'b111 && bus_o[3*k +: 3] == 3'b000) ||
            bus_o[3*k +: 3] == 3'b000 || bus_o[3*k +: 3] == 3'b111) begin
          fails++;
          $display("FAIL R5 actual=%0h expected=no all-equal word after %0h",
                   bus_o, last_bus);
        end
      end
    end
    last_bus = bus_o;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] cur, prev;
    #1;
    // R2 reset state
    @(negedge clk);
    check("R2 bus", bus_o, 6'b001_001);
    check("R2 rx_data", rx_data, 0);
    check("R2 rx_valid", rx_valid, 0);
    check("R2 rx_err", rx_err, 0);
    rst_n = 1'b1;
    step();

    // R1/R3/R6/R8 table walk
    for (int i = 0; i < 8; i++) begin
      tx_data = VEC[i][9:6];
      tx_valid = 1'b1;
      step();
      tx_valid = 1'b0;
      check("R1 R3 encode", bus_o, VEC[i][5:0]);
      step();
      check("R6 R8 decode", rx_data, VEC[i][9:6]);
      check("R6 valid", rx_valid, 1);
    end

    // R4 idle hold with changing data
    tx_valid = 1'b0;
    tx_data = 4'b0000;
    step();
    check("R4 hold", bus_o, 6'b011_011);
    tx_data = 4'b1001;
    step();
    check("R4 hold", bus_o, 6'b011_011);
    check("R4 rx steady", rx_data, 4'b1111);

    // R7 illegal words on lane 0 while lane 1 stays legal
    begin
      logic [2:0] bad [4] = '{3'b111, 3'b000, 3'b101, 3'b110};
      for (int j = 0; j < 4; j++) begin
        inj_word = {3'b010, bad[j]};
        inj = 1'b1;
        step();
        check("R7 err lane0", rx_err, 2'b01);
        check("R7 valid low", rx_valid, 0);
        check("R7 lane1 data", rx_data[3:2], 2'b01);
      end
      inj_word = {3'b000, 3'b100};
      step();
      check("R7 err lane1", rx_err, 2'b10);
      check("R7 valid low", rx_valid, 0);
      inj = 1'b0;
      step();
      check("R7 recover", rx_err, 0);
      check("R7 recover data", rx_data, 4'b1111);
    end

    // R8 random streaming round trip
    cur = 4'b1111;
    prev = 4'b1111;
    for (int n = 0; n < 400; n++) begin
      tx_data = 4'($urandom);
      tx_valid = 1'($urandom);
      @(posedge clk);
      prev = cur;
      if (tx_valid) cur = tx_data;
      @(negedge clk);
      check("R3 R4 stream bus", bus_o, model_bus(cur));
      check("R8 stream rx", rx_data, prev);
      check("R8 stream valid", rx_valid, 1);
    end

    // R2 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R2 async bus", bus_o, 6'b001_001);
    check("R2 async valid", rx_valid, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule